// File: doc/BRIEF.md
# Data-Processing ALU with NZCV Flag Update

This block is the integer data-processing stage of a processor's execute unit. Each cycle it takes two operands, a 4-bit operation code, a flag-update request and the current condition flags. The second operand arrives already shifted or already expanded from an immediate, and the shifter's carry-out comes with it. The block returns the operation result, a write enable for the destination register and the next value of the negative, zero, carry and overflow flags.

Sixteen operations share one adder and one bitwise unit. They are: four bitwise logic operations, two moves, six add and subtract forms (with and without carry, and reversed), and four test and compare forms. The test and compare forms only produce flags. All outputs are registered, so they appear one clock after the inputs are presented.

Top module: `dp_alu`

## Requirements
- R1: The operation code selects the result as follows: 0000 a AND b, 0001 a XOR b, 1100 a OR b, 1101 b, 1110 a AND NOT b, 1111 NOT b, where a is op1_i and b is op2_i.
- R2: The arithmetic codes produce: 0010 a-b, 0011 b-a, 0100 a+b, 0101 a+b+C, 0110 a-b-(1-C), 0111 b-a-(1-C), all taken modulo 2^WIDTH. C is flags_i[1].
- R3: Codes 1000 to 1011 hold write_en_o low and drive result_o with a AND b, a XOR b, a-b and a+b respectively. Every other code raises write_en_o.
- R4: Codes 1000 to 1011 update the flags even when set_flags_i is 0.
- R5: For any code outside 1000 to 1011 with set_flags_i at 0, flags_o equals flags_i.
- R6: Flags are packed as {N,Z,C,V} in bits 3..0. When flags update, N equals the result's top bit and Z is set exactly when the result is zero.
- R7: When an arithmetic code or a compare code (1010, 1011) updates flags, C is the adder carry-out, so subtraction gives C=1 when no borrow occurs. V is set on two's-complement signed overflow.
- R8: When a logic, move or bit-test code updates flags, C takes shift_carry_i and V keeps flags_i[0].
- R9: Carry-in for codes 0101, 0110 and 0111 is the incoming C flag. The subtract-with-carry forms therefore take off one extra unit when C is 0.
- R10: Outputs are registered with one cycle of latency. While rst_ni is low, result_o, write_en_o and flags_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op1_i | input | WIDTH | First operand |
| op2_i | input | WIDTH | Second operand, already shifted or immediate |
| opcode_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Request flag update |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| shift_carry_i | input | 1 | Carry-out of the operand-2 shifter |
| result_o | output | WIDTH | Operation result |
| write_en_o | output | 1 | Destination register write enable |
| flags_o | output | 4 | Next flags {N,Z,C,V} |

## Verification
The bench builds the block with WIDTH at its default of 32. At that width the sign boundary pairs 0x7FFFFFFF/0x80000000 and the all-ones carry ripple are directed cases, while random operands cover ordinary values. Random opcodes, flag inputs and set-flag bits are crossed so that the carry-in rules for the subtract-with-carry forms and the compare-without-S path are hit with both carry polarities.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'b0000, OP_EOR = 4'b0001, OP_SUB = 4'b0010, OP_RSB = 4'b0011,
    OP_ADD = 4'b0100, OP_ADC = 4'b0101, OP_SBC = 4'b0110, OP_RSC = 4'b0111,
    OP_TST = 4'b1000, OP_TEQ = 4'b1001, OP_CMP = 4'b1010, OP_CMN = 4'b1011,
    OP_ORR = 4'b1100, OP_MOV = 4'b1101, OP_BIC = 4'b1110, OP_MVN = 4'b1111
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic op_is_test(input alu_op_e op);
    return op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN};
  endfunction

  function automatic logic op_is_arith(input alu_op_e op);
    return op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN};
  endfunction
endpackage

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      OP_AND, OP_TST: y_o = a_i & b_i;
      OP_EOR, OP_TEQ: y_o = a_i ^ b_i;
      OP_ORR:         y_o = a_i | b_i;
      OP_MOV:         y_o = b_i;
      OP_BIC:         y_o = a_i & ~b_i;
      OP_MVN:         y_o = ~b_i;
      default:        y_o = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu_arith.sv
module dp_alu_arith
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_o,
  output logic             v_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] x, y;
  logic             cin;
  logic [WIDTH:0]   full;

  // Operand steering: reverse forms swap, subtract forms invert
  always_comb begin
    unique case (op_i)
      OP_SUB, OP_CMP: begin x = a_i; y = ~b_i; cin = 1'b1; end
      OP_RSB:         begin x = b_i; y = ~a_i; cin = 1'b1; end
      OP_ADC:         begin x = a_i; y = b_i;  cin = c_i;  end
      OP_SBC:         begin x = a_i; y = ~b_i; cin = c_i;  end
      OP_RSC:         begin x = b_i; y = ~a_i; cin = c_i;  end
      default:        begin x = a_i; y = b_i;  cin = 1'b0; end
    endcase
  end

  assign full  = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
  assign sum_o = full[MSB:0];
  assign c_o   = full[WIDTH];
  assign v_o   = (x[MSB] == y[MSB]) && (full[MSB] != x[MSB]);
endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic             set_i,
  input  nzcv_t            flags_i,
  input  logic [WIDTH-1:0] res_i,
  input  logic             add_c_i,
  input  logic             add_v_i,
  input  logic             shc_i,
  output nzcv_t            flags_o,
  output logic             we_o
);
  logic upd, arith;

  assign arith = op_is_arith(op_i);
  assign upd   = set_i | op_is_test(op_i);
  assign we_o  = ~op_is_test(op_i);

  always_comb begin
    flags_o = flags_i;
    if (upd) begin
      flags_o.n = res_i[WIDTH-1];
      flags_o.z = (res_i == '0);
      flags_o.c = arith ? add_c_i : shc_i;
      flags_o.v = arith ? add_v_i : flags_i.v;
    end
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] op1_i,
  input  logic [WIDTH-1:0] op2_i,
  input  logic [3:0]       opcode_i,
  input  logic             set_flags_i,
  input  logic [3:0]       flags_i,
  input  logic             shift_carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             write_en_o,
  output logic [3:0]       flags_o
);
  alu_op_e          op;
  nzcv_t            f_in, f_nxt;
  logic [WIDTH-1:0] log_y, add_y, res;
  logic             add_c, add_v, we;

  assign op   = alu_op_e'(opcode_i);
  assign f_in = nzcv_t'(flags_i);

  dp_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .op_i(op), .a_i(op1_i), .b_i(op2_i), .y_o(log_y)
  );

  dp_alu_arith #(.WIDTH(WIDTH)) u_arith (
    .op_i(op), .a_i(op1_i), .b_i(op2_i), .c_i(f_in.c),
    .sum_o(add_y), .c_o(add_c), .v_o(add_v)
  );

  assign res = op_is_arith(op) ? add_y : log_y;

  dp_alu_flags #(.WIDTH(WIDTH)) u_flags (
    .op_i(op), .set_i(set_flags_i), .flags_i(f_in), .res_i(res),
    .add_c_i(add_c), .add_v_i(add_v), .shc_i(shift_carry_i),
    .flags_o(f_nxt), .we_o(we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o   <= '0;
      write_en_o <= 1'b0;
      flags_o    <= '0;
    end else begin
      result_o   <= res;
      write_en_o <= we;
      flags_o    <= f_nxt;
    end
  end
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       opcode_i,
  input logic             set_flags_i,
  input logic [3:0]       flags_i,
  input logic [WIDTH-1:0] result_o,
  input logic             write_en_o,
  input logic [3:0]       flags_o
);
  logic armed;
  logic is_test, is_logic;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assign is_test  = (opcode_i[3:2] == 2'b10);
  assign is_logic = opcode_i inside {4'b0000, 4'b0001, 4'b1000, 4'b1001,
                                     4'b1100, 4'b1101, 4'b1110, 4'b1111};

  assert_no_write_on_test_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(is_test) |-> !write_en_o);

  assert_write_on_other_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(!is_test) |-> write_en_o);

  assert_flags_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(!set_flags_i && !is_test) |-> flags_o == $past(flags_i));

  assert_nz_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(set_flags_i || is_test) |->
      (flags_o[3] == result_o[WIDTH-1]) && (flags_o[2] == (result_o == '0)));

  assert_logic_v_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past((set_flags_i || is_test) && is_logic) |-> flags_o[0] == $past(flags_i[0]));
endmodule

bind dp_alu dp_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .opcode_i(opcode_i), .set_flags_i(set_flags_i),
  .flags_i(flags_i), .result_o(result_o), .write_en_o(write_en_o), .flags_o(flags_o)
);

// File: tb/tb_dp_alu.sv
`timescale 1ns/1ps
module tb_dp_alu;
  localparam int W = 32;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] op1_i = '0, op2_i = '0;
  logic [3:0]   opcode_i = '0, flags_i = '0;
  logic         set_flags_i = 1'b0, shift_carry_i = 1'b0;
  logic [W-1:0] result_o;
  logic         write_en_o;
  logic [3:0]   flags_o;

  int checks = 0, errors = 0;

  always #10 clk_i = ~clk_i;

  dp_alu #(.WIDTH(W)) dut (.*);

  // Reference model built from the requirement text
  function automatic void model(input logic [3:0] op, input logic [W-1:0] a, b,
                                input logic s, input logic [3:0] f, input logic sc,
                                output logic [W-1:0] r, output logic we, output logic [3:0] nf);
    logic [W:0] t;
    logic ar, tst, cy, ov, c;
    c   = f[1];
    ar  = 1'b1;
    tst = (op[3:2] == 2'b10);
    t   = '0;
    r   = '0;
    case (op)
      4'd2, 4'd10: t = {1'b0, a} + {1'b0, ~b} + 1;
      4'd3:        t = {1'b0, b} + {1'b0, ~a} + 1;
      4'd4, 4'd11: t = {1'b0, a} + {1'b0, b};
      4'd5:        t = {1'b0, a} + {1'b0, b} + c;
      4'd6:        t = {1'b0, a} + {1'b0, ~b} + c;
      4'd7:        t = {1'b0, b} + {1'b0, ~a} + c;
      default:     ar = 1'b0;
    endcase
    case (op)
      4'd0, 4'd8:  r = a & b;
      4'd1, 4'd9:  r = a ^ b;
      4'd12:       r = a | b;
      4'd13:       r = b;
      4'd14:       r = a & ~b;
      4'd15:       r = ~b;
      default:     r = t[W-1:0];
    endcase
    cy = t[W];
    case (op)
      4'd2, 4'd6, 4'd10: ov = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
      4'd3, 4'd7:        ov = (a[W-1] != b[W-1]) && (r[W-1] != b[W-1]);
      default:           ov = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
    endcase
    we = !tst;
    if (s || tst) nf = {r[W-1], (r == '0), ar ? cy : sc, ar ? ov : f[0]};
    else          nf = f;
  endfunction

  task automatic run(input string tag, input logic [3:0] op, input logic [W-1:0] a, b,
                     input logic s, input logic [3:0] f, input logic sc);
    logic [W-1:0] er;
    logic ew;
    logic [3:0] ef;
    model(op, a, b, s, f, sc, er, ew, ef);
    @(negedge clk_i);
    opcode_i = op; op1_i = a; op2_i = b; set_flags_i = s; flags_i = f; shift_carry_i = sc;
    @(posedge clk_i);
    #2;
    checks++;
    if (result_o !== er || write_en_o !== ew || flags_o !== ef) begin
      errors++;
      $display("FAIL %s op=%b: actual r=%h we=%b f=%b expected r=%h we=%b f=%b",
               tag, op, result_o, write_en_o, flags_o, er, ew, ef);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    if (op[3:2] == 2'b10) return "R3/R4";
    if (op inside {4'd5, 4'd6, 4'd7}) return "R9";
    if (op inside {4'd2, 4'd3, 4'd4}) return "R2";
    return "R1";
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd1234);
    // R10: outputs zero during reset despite live inputs
    op1_i = 32'h1234_5678; op2_i = 32'h0F0F_0F0F; opcode_i = 4'd4; flags_i = 4'hF; set_flags_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #2;
    checks++;
    if (result_o !== '0 || write_en_o !== 1'b0 || flags_o !== 4'h0) begin
      errors++;
      $display("FAIL R10 reset: actual r=%h we=%b f=%b expected zeros", result_o, write_en_o, flags_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // Directed corners
    run("R7 add signed overflow",   4'd4,  32'h7FFF_FFFF, 32'h1, 1'b1, 4'h0, 1'b0);
    run("R7 add carry out zero",    4'd4,  32'hFFFF_FFFF, 32'h1, 1'b1, 4'h0, 1'b0);
    run("R7 sub equal no borrow",   4'd2,  32'd5, 32'd5, 1'b1, 4'h0, 1'b0);
    run("R7 sub borrow",            4'd2,  32'd3, 32'd5, 1'b1, 4'h0, 1'b0);
    run("R7 sub signed overflow",   4'd2,  32'h8000_0000, 32'h1, 1'b1, 4'h0, 1'b0);
    run("R9 sbc carry clear",       4'd6,  32'd10, 32'd3, 1'b1, 4'h0, 1'b0);
    run("R9 sbc carry set",         4'd6,  32'd10, 32'd3, 1'b1, 4'h2, 1'b0);
    run("R9 adc carry set",         4'd5,  32'hFFFF_FFFF, 32'h0, 1'b1, 4'h2, 1'b0);
    run("R9 rsc carry clear",       4'd7,  32'd3, 32'd10, 1'b0, 4'h0, 1'b0);
    run("R2 rsb",                   4'd3,  32'd7, 32'd2, 1'b0, 4'h5, 1'b0);
    run("R3 cmp no write",          4'd10, 32'd9, 32'd9, 1'b1, 4'h0, 1'b0);
    run("R4 cmp without S",         4'd10, 32'd1, 32'd2, 1'b0, 4'h0, 1'b0);
    run("R4 tst without S",         4'd8,  32'hF0, 32'h08, 1'b0, 4'hF, 1'b1);
    run("R4 teq equal without S",   4'd9,  32'hABCD, 32'hABCD, 1'b0, 4'h1, 1'b0);
    run("R4 cmn wrap",              4'd11, 32'hFFFF_FFFF, 32'h1, 1'b0, 4'h0, 1'b0);
    run("R5 add S clear keeps",     4'd4,  32'hFFFF_FFFF, 32'h1, 1'b0, 4'hA, 1'b0);
    run("R5 mvn S clear keeps",     4'd15, 32'h0, 32'h8, 1'b0, 4'h5, 1'b1);
    run("R8 mov shifter carry",     4'd13, 32'h0, 32'h8000_0000, 1'b1, 4'h1, 1'b1);
    run("R8 bic zero V kept",       4'd14, 32'hFF, 32'hFF, 1'b1, 4'h3, 1'b0);
    run("R1 mvn of eight",          4'd15, 32'h0, 32'h8, 1'b1, 4'h0, 1'b0);
    run("R6 orr zero",              4'd12, 32'h0, 32'h0, 1'b1, 4'h8, 1'b0);

    // Random sweep over all opcodes
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] op;
      logic [W-1:0] a, b;
      op = 4'($urandom);
      a  = $urandom;
      b  = $urandom;
      if ((i % 7) == 0) b = a;
      if ((i % 11) == 0) a = 32'h8000_0000;
      run(tag_of(op), op, a, b, 1'($urandom), 4'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule